// File: doc/BRIEF.md
# Issue-Stage Hazard Scoreboard

This block sits at the end of instruction decode in an in-order pipeline whose execution units have different depths: a single-stage integer ALU, a load path, pipelined floating-point add and multiply units, and a floating-point divider that accepts a new operation only after the previous one finishes. In every cycle it looks at the instruction held in decode and decides whether that instruction may enter execution or must wait in decode. It raises `stall` when the instruction must wait. Otherwise it raises `issue` and reports the unit that receives the instruction.

For each architectural register, with the integer and floating-point files kept apart, the block keeps a countdown. The countdown gives the number of cycles left before that register's pending result can be forwarded to a consumer entering execution. At issue, an instruction that writes a register loads that register's countdown with its unit's latency minus one. From then on the countdown falls by one per clock until it reaches zero. A read-after-write dependence holds the consumer until the countdown is zero. Store data has relaxed timing because the value is needed only at the memory stage, so it waits only while the countdown is above one. A write-after-write conflict holds the later writer until the earlier writer's countdown is zero. A divide is held while the divider is occupied. The operand forwarding paths and the units themselves lie outside this block.

Top module: `iss_scoreboard`

## Requirements
- R1: After reset, no register is pending and the divider is free. With `dec_valid` low, `stall` and `issue` are both 0, and the first instruction presented issues in the same cycle.
- R2: `issue` equals `dec_valid` and not `stall`. While `issue` is high, `issue_unit` equals `dec_unit`. The unit encoding is 0 integer ALU, 1 load, 2 store, 3 FP add, 4 FP multiply and 5 FP divide.
- R3: A consumer of an integer ALU result issues in the cycle right after its producer issues, with no stall.
- R4: A consumer of a register written by a unit of latency L waits exactly L-1 cycles after its producer issues. It issues in the same cycle the countdown reaches zero, because a register written and read in one cycle returns the new value.
- R5: A consumer that uses a load result, with a load latency of 2, stalls exactly one cycle.
- R6: For a store (code 2), source 2 is the store data and waits only while its countdown is above one, which is one cycle less than for other consumers. Source 1 is the address and follows the normal rule.
- R7: An instruction whose destination has a non-zero countdown stalls until that countdown reaches zero. This holds even when it reads no pending source.
- R8: Each register file is tracked on its own. A pending entry in one file never stalls an access to the same index in the other file. Each source and the destination carry a file select (1 selects floating point).
- R9: After a divide issues, a second divide stalls until FDIV_LAT cycles have passed since the first issued. Instructions of other units are not delayed by a busy divider.
- R10: Countdowns keep falling during cycles with `dec_valid` low, and in those cycles neither `stall` nor `issue` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction present in decode |
| dec_unit | input | 3 | Target unit code |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_dst_fp | input | 1 | Destination file select |
| dec_dst | input | RW | Destination index |
| dec_s1_en | input | 1 | Source 1 used |
| dec_s1_fp | input | 1 | Source 1 file select |
| dec_s1 | input | RW | Source 1 index |
| dec_s2_en | input | 1 | Source 2 used |
| dec_s2_fp | input | 1 | Source 2 file select |
| dec_s2 | input | RW | Source 2 index (store data for stores) |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | Instruction enters execution this cycle |
| issue_unit | output | 3 | Unit receiving the issued instruction |

## Verification
The bench builds the block with eight registers per file, an FP add latency of 5, an FP multiply latency of 10, a divider occupancy of 8 and a load latency of 2. The short divider occupancy lets a divide that is blocked behind another divide be followed to its release within a few cycles. The eight-entry files keep every index in reach while the same index is reused across the two files. The chosen latencies give distinct stall counts of 1, 4, 8 and 9, and each scenario checks both the exact count and a per-cycle comparison against the reference model.

// File: rtl/iss_pkg.sv
package iss_pkg;

  typedef enum logic [2:0] {
    U_INT   = 3'd0,
    U_LOAD  = 3'd1,
    U_STORE = 3'd2,
    U_FADD  = 3'd3,
    U_FMUL  = 3'd4,
    U_FDIV  = 3'd5
  } unit_e;

  // Cycles from issue until a dependent consumer may enter execution.
  function automatic int unsigned unit_lat(unit_e u, int unsigned l_int,
                                           int unsigned l_ld, int unsigned l_add,
                                           int unsigned l_mul, int unsigned l_div);
    case (u)
      U_LOAD:  return l_ld;
      U_FADD:  return l_add;
      U_FMUL:  return l_mul;
      U_FDIV:  return l_div;
      default: return l_int;
    endcase
  endfunction

  function automatic int unsigned max5(int unsigned a, int unsigned b, int unsigned c,
                                       int unsigned d, int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // A source is blocked while its countdown exceeds its slack.
  function automatic logic src_blocked(int unsigned cnt, logic relaxed);
    return relaxed ? (cnt > 1) : (cnt != 0);
  endfunction

endpackage

// File: rtl/iss_pend_track.sv
module iss_pend_track #(
  parameter int NREG = 32,
  parameter int CW   = 5,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [RW-1:0] set_idx,
  input  logic [CW-1:0] set_cnt,
  input  logic [RW-1:0] rd_a_idx,
  input  logic [RW-1:0] rd_b_idx,
  input  logic [RW-1:0] rd_c_idx,
  output logic [CW-1:0] rd_a_cnt,
  output logic [CW-1:0] rd_b_cnt,
  output logic [CW-1:0] rd_c_cnt
);

  logic [CW-1:0] cnt_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[i] <= '0;
      else if (set_en && set_idx == RW'(i))
        cnt_q[i] <= set_cnt;
      else if (cnt_q[i] != '0)
        cnt_q[i] <= cnt_q[i] - 1'b1;
    end
  end

  assign rd_a_cnt = cnt_q[rd_a_idx];
  assign rd_b_cnt = cnt_q[rd_b_idx];
  assign rd_c_cnt = cnt_q[rd_c_idx];

endmodule

// File: rtl/iss_div_track.sv
module iss_div_track #(
  parameter int DIV_LAT = 30,
  localparam int DW     = $clog2(DIV_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [DW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (start)
      left_q <= DW'(DIV_LAT - 1);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/iss_scoreboard.sv
module iss_scoreboard
  import iss_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int INT_LAT   = 1,
  parameter int LOAD_LAT  = 2,
  parameter int FADD_LAT  = 5,
  parameter int FMUL_LAT  = 10,
  parameter int FDIV_LAT  = 30,
  localparam int RW       = $clog2(NREG),
  localparam int MAXL     = max5(INT_LAT, LOAD_LAT, FADD_LAT, FMUL_LAT, FDIV_LAT),
  localparam int CW       = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [2:0]    dec_unit,
  input  logic          dec_dst_en,
  input  logic          dec_dst_fp,
  input  logic [RW-1:0] dec_dst,
  input  logic          dec_s1_en,
  input  logic          dec_s1_fp,
  input  logic [RW-1:0] dec_s1,
  input  logic          dec_s2_en,
  input  logic          dec_s2_fp,
  input  logic [RW-1:0] dec_s2,
  output logic          stall,
  output logic          issue,
  output logic [2:0]    issue_unit
);

  unit_e         unit;
  logic          is_store, is_div, writes;
  logic [CW-1:0] i_a, i_b, i_c, f_a, f_b, f_c;
  logic [CW-1:0] s1_cnt, s2_cnt, dst_cnt, new_cnt;
  logic          raw_hit, waw_hit, div_hit, div_busy;
  logic          set_int, set_fp;

  assign unit     = unit_e'(dec_unit);
  assign is_store = (unit == U_STORE);
  assign is_div   = (unit == U_FDIV);
  assign writes   = dec_dst_en && !is_store;
  assign new_cnt  = CW'(unit_lat(unit, INT_LAT, LOAD_LAT, FADD_LAT, FMUL_LAT, FDIV_LAT) - 1);

  assign set_int = issue && writes && !dec_dst_fp;
  assign set_fp  = issue && writes &&  dec_dst_fp;

  iss_pend_track #(.NREG(NREG), .CW(CW)) u_int_trk (
    .clk(clk), .rst_n(rst_n), .set_en(set_int), .set_idx(dec_dst), .set_cnt(new_cnt),
    .rd_a_idx(dec_s1), .rd_b_idx(dec_s2), .rd_c_idx(dec_dst),
    .rd_a_cnt(i_a), .rd_b_cnt(i_b), .rd_c_cnt(i_c)
  );

  iss_pend_track #(.NREG(NREG), .CW(CW)) u_fp_trk (
    .clk(clk), .rst_n(rst_n), .set_en(set_fp), .set_idx(dec_dst), .set_cnt(new_cnt),
    .rd_a_idx(dec_s1), .rd_b_idx(dec_s2), .rd_c_idx(dec_dst),
    .rd_a_cnt(f_a), .rd_b_cnt(f_b), .rd_c_cnt(f_c)
  );

  iss_div_track #(.DIV_LAT(FDIV_LAT)) u_div_trk (
    .clk(clk), .rst_n(rst_n), .start(issue && is_div), .busy(div_busy)
  );

  assign s1_cnt  = dec_s1_fp  ? f_a : i_a;
  assign s2_cnt  = dec_s2_fp  ? f_b : i_b;
  assign dst_cnt = dec_dst_fp ? f_c : i_c;

  assign raw_hit = (dec_s1_en && src_blocked(int'(s1_cnt), 1'b0)) ||
                   (dec_s2_en && src_blocked(int'(s2_cnt), is_store));
  assign waw_hit = writes && (dst_cnt != '0);
  assign div_hit = is_div && div_busy;

  assign stall      = dec_valid && (raw_hit || waw_hit || div_hit);
  assign issue      = dec_valid && !stall;
  assign issue_unit = dec_unit;

endmodule

// File: rtl/iss_scoreboard_chk.sv
module iss_scoreboard_chk
  import iss_pkg::*;
#(
  parameter int FDIV_LAT = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_valid,
  input logic [2:0] dec_unit,
  input logic       stall,
  input logic       issue,
  input logic       waw_hit,
  input logic       div_busy
);

  a_r2_issue_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (dec_valid && !stall));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && !issue));

  a_r9_div_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_unit == U_FDIV && FDIV_LAT > 1) |=> div_busy);

  a_r9_div_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_unit == U_FDIV && div_busy) |-> !issue);

  a_r7_waw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && waw_hit) |-> (stall && !issue));

  a_r9_div_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_busy && !(issue && dec_unit == U_FDIV)) |=> !div_busy);

endmodule

bind iss_scoreboard iss_scoreboard_chk #(.FDIV_LAT(FDIV_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
  .stall(stall), .issue(issue), .waw_hit(waw_hit), .div_busy(div_busy)
);

// File: tb/sim_iss_scoreboard.sv
module sim_iss_scoreboard;

  localparam int CLK_P = 10;
  localparam int NREG = 8, RW = 3;
  localparam int L_INT = 1, L_LD = 2, L_ADD = 5, L_MUL = 10, L_DIV = 8;
  localparam int UI = 0, UL = 1, US = 2, UA = 3, UM = 4, UD = 5;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_dst_en = 0, dec_dst_fp = 0;
  logic dec_s1_en = 0, dec_s1_fp = 0, dec_s2_en = 0, dec_s2_fp = 0;
  logic [2:0] dec_unit = 0;
  logic [RW-1:0] dec_dst = 0, dec_s1 = 0, dec_s2 = 0;
  logic stall, issue;
  logic [2:0] issue_unit;

  int checks = 0, fails = 0, cyc = 0;
  int rdy_i [NREG];
  int rdy_f [NREG];
  int div_free = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  iss_scoreboard #(.NREG(NREG), .INT_LAT(L_INT), .LOAD_LAT(L_LD), .FADD_LAT(L_ADD),
                   .FMUL_LAT(L_MUL), .FDIV_LAT(L_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_dst_en(dec_dst_en), .dec_dst_fp(dec_dst_fp), .dec_dst(dec_dst),
    .dec_s1_en(dec_s1_en), .dec_s1_fp(dec_s1_fp), .dec_s1(dec_s1),
    .dec_s2_en(dec_s2_en), .dec_s2_fp(dec_s2_fp), .dec_s2(dec_s2),
    .stall(stall), .issue(issue), .issue_unit(issue_unit)
  );

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int rdy(bit fp, int idx);
    return fp ? rdy_f[idx] : rdy_i[idx];
  endfunction

  function automatic int lat(int u);
    case (u)
      UL: return L_LD;
      UA: return L_ADD;
      UM: return L_MUL;
      UD: return L_DIV;
      default: return L_INT;
    endcase
  endfunction

  function automatic bit model_stall();
    bit s = 0;
    if (!dec_valid) return 0;
    if (dec_s1_en && cyc < rdy(dec_s1_fp, int'(dec_s1))) s = 1;
    if (dec_s2_en && cyc < rdy(dec_s2_fp, int'(dec_s2)) - (dec_unit == US ? 1 : 0)) s = 1;
    if (dec_dst_en && dec_unit != US && cyc < rdy(dec_dst_fp, int'(dec_dst))) s = 1;
    if (dec_unit == UD && cyc < div_free) s = 1;
    return s;
  endfunction

  task automatic tick(string tag, output bit issued);
    bit es, ei;
    #1;
    es = model_stall();
    ei = dec_valid && !es;
    chk({tag, " stall"}, stall == es, int'(stall), int'(es));
    chk({tag, " issue"}, issue == ei, int'(issue), int'(ei));
    if (ei) chk({tag, " R2 unit"}, issue_unit == dec_unit, int'(issue_unit), int'(dec_unit));
    @(posedge clk);
    if (ei) begin
      if (dec_dst_en && dec_unit != US) begin
        if (dec_dst_fp) rdy_f[dec_dst] = cyc + lat(int'(dec_unit));
        else            rdy_i[dec_dst] = cyc + lat(int'(dec_unit));
      end
      if (dec_unit == UD) div_free = cyc + L_DIV;
    end
    cyc++;
    issued = ei;
    @(negedge clk);
  endtask

  task automatic send(string tag, int u, bit de, bit dfp, int d,
                      bit a_en, bit a_fp, int a, bit b_en, bit b_fp, int b, int exp_st);
    bit got = 0;
    int n = 0;
    dec_valid = 1; dec_unit = 3'(u);
    dec_dst_en = de; dec_dst_fp = dfp; dec_dst = RW'(d);
    dec_s1_en = a_en; dec_s1_fp = a_fp; dec_s1 = RW'(a);
    dec_s2_en = b_en; dec_s2_fp = b_fp; dec_s2 = RW'(b);
    while (!got && n < 60) begin
      tick(tag, got);
      if (!got) n++;
    end
    dec_valid = 0;
    if (exp_st >= 0) chk({tag, " stall count"}, n == exp_st, n, exp_st);
  endtask

  task automatic idle(string tag, int n);
    bit g;
    dec_valid = 0;
    for (int i = 0; i < n; i++) tick(tag, g);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin rdy_i[i] = 0; rdy_f[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle("R1 reset", 2);
    // R1: first instruction after reset issues at once
    send("R1 first", UM, 1, 1, 0, 1, 1, 1, 1, 1, 2, 0);
    idle("R10 drain", 10);
    // R3: integer back-to-back
    send("R3 prod", UI, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    send("R3 cons", UI, 1, 0, 2, 1, 0, 1, 0, 0, 0, 0);
    // R4: FP add and multiply gaps
    send("R4 add", UA, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    send("R4 addcons", UA, 1, 1, 3, 0, 0, 0, 1, 1, 2, 4);
    send("R4 mul", UM, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    send("R4 mulcons", UI, 1, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    send("R4 mulcons2", UA, 1, 1, 4, 1, 1, 1, 0, 0, 0, 8);
    // R5: load-use
    send("R5 load", UL, 1, 0, 4, 0, 0, 0, 0, 0, 0, 0);
    send("R5 use", UI, 1, 0, 5, 0, 0, 0, 1, 0, 4, 1);
    // R6: store data relaxed, store address normal
    send("R6 mul", UM, 1, 1, 5, 0, 0, 0, 0, 0, 0, 0);
    send("R6 st data", US, 0, 0, 0, 1, 0, 2, 1, 1, 5, 8);
    send("R6 load", UL, 1, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    send("R6 st addr", US, 0, 0, 0, 1, 0, 6, 0, 0, 0, 1);
    send("R6 load2", UL, 1, 0, 7, 0, 0, 0, 0, 0, 0, 0);
    send("R6 st ldata", US, 0, 0, 0, 0, 0, 0, 1, 0, 7, 0);
    // R7: WAW with no pending source
    send("R7 mul", UM, 1, 1, 6, 0, 0, 0, 0, 0, 0, 0);
    send("R7 waw", UA, 1, 1, 6, 0, 0, 0, 0, 0, 0, 9);
    // R8: same index, other file
    send("R8 mul", UM, 1, 1, 7, 0, 0, 0, 0, 0, 0, 0);
    send("R8 int rd", UI, 1, 0, 7, 1, 0, 7, 0, 0, 0, 0);
    // R9: divider occupancy
    send("R9 div1", UD, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R9 add", UA, 1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    send("R9 div2", UD, 1, 1, 4, 0, 0, 0, 0, 0, 0, 6);
    idle("R10 gap", 12);
    // R10: countdown runs during idle cycles
    send("R10 mul", UM, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    idle("R10 idle", 5);
    send("R10 cons", UI, 1, 0, 0, 1, 1, 1, 0, 0, 0, 4);
    idle("R10 end", 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule